// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two parallel data ports, A and B, and keeps one storage register for each direction. The A-side register samples port A on the rising edge of its own capture clock. The B-side register samples port B on the rising edge of a second, independent capture clock. An active-low output enable and a direction input choose which port is driven, if either. For each direction, a select input chooses what the driven port carries: the live value of the opposite port, or the register that holds that port's stored data.

Each port is split into an input, an output and an output enable, so the block can be synthesized inside a chip. The pad or tri-state logic outside the block combines them. Each register samples the resolved value of its port. On an undriven port that is the external input. On a driven port it is the value the block itself drives. Loading never depends on the output enable or the direction. An active-low asynchronous reset stands in for power sequencing. It clears both registers and keeps both ports undriven.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a rising edge of `clk_ab_i` the A-side register loads the resolved port A value. On a rising edge of `clk_ba_i` the B-side register loads the resolved port B value. Each register loads only on its own clock.
- R2: Register loading does not depend on `oe_ni` or `dir_i`. Both registers load, together or separately, while both ports are undriven.
- R3: While `oe_ni` is 1, `a_oe_o` and `b_oe_o` are both 0.
- R4: While `oe_ni` is 0 and reset is released, `dir_i`=0 drives port A (`a_oe_o`=1, `b_oe_o`=0) and `dir_i`=1 drives port B (`b_oe_o`=1, `a_oe_o`=0).
- R5: `a_oe_o` and `b_oe_o` are never 1 at the same time.
- R6: While port A is driven, `sel_ba_i`=0 makes `a_o` equal `b_i`, and `sel_ba_i`=1 makes `a_o` equal the B-side register.
- R7: While port B is driven, `sel_ab_i`=0 makes `b_o` equal `a_i`, and `sel_ab_i`=1 makes `b_o` equal the A-side register.
- R8: While `rst_ni` is 0, both output enables are 0. Reset clears both registers to 0.
- R9: A register clocked while its own port is driven loads the driven value, which is the data passed through from the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset (power sequencing) |
| clk_ab_i | input | 1 | Capture clock of the A-side register |
| clk_ba_i | input | 1 | Capture clock of the B-side register |
| oe_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 0 drives port A, 1 drives port B |
| sel_ab_i | input | 1 | Port B source: 0 live A, 1 A-side register |
| sel_ba_i | input | 1 | Port A source: 0 live B, 1 B-side register |
| a_i | input | WIDTH | External value on port A |
| a_o | output | WIDTH | Value driven onto port A |
| a_oe_o | output | 1 | Port A output enable |
| b_i | input | WIDTH | External value on port B |
| b_o | output | WIDTH | Value driven onto port B |
| b_oe_o | output | 1 | Port B output enable |

## Verification
The data assertions assume that every port input holds a known value once reset is released. They check nothing while an input is unknown. The bench meets this assumption by driving every control and data input to a defined level from time zero. It changes inputs and capture-clock edges only on the falling edge of its reference clock, and it samples outputs on the rising edge. As a result, a capture edge never coincides with a data change at the port it samples.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drv_e;
endpackage

// File: rtl/bus_xcvr_capture.sv
module bus_xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/bus_xcvr_ctrl.sv
module bus_xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  drv_e drv;

  always_comb begin
    if (!rst_ni || oe_ni) drv = DRV_NONE;
    else if (dir_i)       drv = DRV_B;
    else                  drv = DRV_A;
  end

  assign a_oe_o = (drv == DRV_A);
  assign b_oe_o = (drv == DRV_B);
endmodule

// File: rtl/bus_xcvr_sel.sv
module bus_xcvr_sel #(
  parameter int WIDTH = 8
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] held_i,
  output logic [WIDTH-1:0] y_o
);
  assign y_o = sel_i ? held_i : live_i;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             oe_ni,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  logic [WIDTH-1:0] reg_a_q, reg_b_q;
  logic [WIDTH-1:0] a_bus, b_bus;

  bus_xcvr_ctrl u_ctrl (
    .rst_ni (rst_ni),
    .oe_ni  (oe_ni),
    .dir_i  (dir_i),
    .a_oe_o (a_oe_o),
    .b_oe_o (b_oe_o)
  );

  // resolved bus: own drive wins over the external input
  assign a_bus = a_oe_o ? a_o : a_i;
  assign b_bus = b_oe_o ? b_o : b_i;

  bus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk_i (clk_ab_i), .rst_ni (rst_ni), .d_i (a_bus), .q_o (reg_a_q)
  );
  bus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk_i (clk_ba_i), .rst_ni (rst_ni), .d_i (b_bus), .q_o (reg_b_q)
  );

  // live source is the raw input of the opposite port, which is undriven whenever this side drives
  bus_xcvr_sel #(.WIDTH(WIDTH)) u_sel_b (
    .sel_i (sel_ab_i), .live_i (a_i), .held_i (reg_a_q), .y_o (b_o)
  );
  bus_xcvr_sel #(.WIDTH(WIDTH)) u_sel_a (
    .sel_i (sel_ba_i), .live_i (b_i), .held_i (reg_b_q), .y_o (a_o)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             dir_i,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] a_o,
  input logic [WIDTH-1:0] b_o,
  input logic             a_oe_o,
  input logic             b_oe_o,
  input logic [WIDTH-1:0] reg_a_q,
  input logic [WIDTH-1:0] reg_b_q
);
  always_comb begin
    if (rst_ni === 1'b0) begin
      a_r8_reset_hiz: assert (!a_oe_o && !b_oe_o) else $error("R8 port driven in reset");
    end
    if (rst_ni === 1'b1 && !$isunknown({oe_ni, dir_i, sel_ab_i, sel_ba_i, a_i, b_i})) begin
      a_r5_one_side: assert (!(a_oe_o && b_oe_o)) else $error("R5 both ports driven");
      if (oe_ni) begin
        a_r3_isolation: assert (!a_oe_o && !b_oe_o) else $error("R3 driven in isolation");
      end else begin
        a_r4_direction: assert (a_oe_o == !dir_i && b_oe_o == dir_i) else $error("R4 wrong side");
      end
      if (a_oe_o) begin
        a_r6_a_source: assert (a_o == (sel_ba_i ? reg_b_q : b_i)) else $error("R6 port A data");
      end
      if (b_oe_o) begin
        a_r7_b_source: assert (b_o == (sel_ab_i ? reg_a_q : a_i)) else $error("R7 port B data");
      end
    end
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_ni   (rst_ni),
  .oe_ni    (oe_ni),
  .dir_i    (dir_i),
  .sel_ab_i (sel_ab_i),
  .sel_ba_i (sel_ba_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .a_o      (a_o),
  .b_o      (b_o),
  .a_oe_o   (a_oe_o),
  .b_oe_o   (b_oe_o),
  .reg_a_q  (reg_a_q),
  .reg_b_q  (reg_b_q)
);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int WIDTH = 8;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0, clk_ab_i = 1'b0, clk_ba_i = 1'b0;
  logic oe_ni = 1'b1, dir_i = 1'b0, sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic [WIDTH-1:0] a_i = '0, b_i = '0, a_o, b_o;
  logic a_oe_o, b_oe_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  bus_xcvr_reg #(.WIDTH(WIDTH)) u_dut (
    .rst_ni (rst_ni), .clk_ab_i (clk_ab_i), .clk_ba_i (clk_ba_i),
    .oe_ni (oe_ni), .dir_i (dir_i), .sel_ab_i (sel_ab_i), .sel_ba_i (sel_ba_i),
    .a_i (a_i), .a_o (a_o), .a_oe_o (a_oe_o),
    .b_i (b_i), .b_o (b_o), .b_oe_o (b_oe_o)
  );

  task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply controls on the falling edge, then sample on the rising edge
  task automatic setc(input logic oe, input logic dir, input logic sab, input logic sba);
    @(negedge clk);
    oe_ni = oe; dir_i = dir; sel_ab_i = sab; sel_ba_i = sba;
    @(posedge clk);
  endtask

  task automatic pulse(input logic ab, input logic ba);
    @(negedge clk);
    clk_ab_i = ab; clk_ba_i = ba;
    @(negedge clk);
    clk_ab_i = 1'b0; clk_ba_i = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    oe_ni = 1'b0;
    @(posedge clk);
    chk("R8 a_oe in reset", a_oe_o, 1'b0);
    chk("R8 b_oe in reset", b_oe_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    setc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4 b_oe dir=1", b_oe_o, 1'b1);
    chk("R8 A-side register cleared", b_o, '0);
    setc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 a_oe dir=0", a_oe_o, 1'b1);
    chk("R5 b_oe off while A driven", b_oe_o, 1'b0);
    chk("R8 B-side register cleared", a_o, '0);
  endtask

  task automatic t_live;
    @(negedge clk); a_i = 8'h3C;
    setc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 live A to B", b_o, 8'h3C);
    @(negedge clk); a_i = 8'hC3;
    @(posedge clk);
    chk("R7 live A follows", b_o, 8'hC3);
    chk("R5 a_oe off while B driven", a_oe_o, 1'b0);
    @(negedge clk); b_i = 8'h96;
    setc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 live B to A", a_o, 8'h96);
  endtask

  task automatic t_store;
    setc(1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); a_i = 8'hA5;
    pulse(1'b1, 1'b0);
    @(negedge clk); a_i = 8'h5A;
    @(posedge clk);
    chk("R1 R7 stored A to B", b_o, 8'hA5);
    setc(1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); b_i = 8'h71;
    pulse(1'b0, 1'b1);
    @(negedge clk); b_i = 8'h00;
    @(posedge clk);
    chk("R1 R6 stored B to A", a_o, 8'h71);
    setc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 A-side untouched by B clock", b_o, 8'hA5);
  endtask

  task automatic t_isolation;
    setc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 a_oe isolated", a_oe_o, 1'b0);
    chk("R3 b_oe isolated", b_oe_o, 1'b0);
    @(negedge clk); a_i = 8'h11; b_i = 8'h22;
    pulse(1'b1, 1'b1);
    @(negedge clk); a_i = 8'hFF; b_i = 8'hEE;
    setc(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2 A stored in isolation", b_o, 8'h11);
    setc(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R2 B stored in isolation", a_o, 8'h22);
  endtask

  task automatic t_passthru;
    @(negedge clk); a_i = 8'hE7;
    setc(1'b0, 1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    @(negedge clk); a_i = 8'h00; b_i = 8'hFF;
    setc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 B-side loads driven B", a_o, 8'hE7);
    pulse(1'b1, 1'b0);
    setc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 A-side loads driven A", b_o, 8'hE7);
  endtask

  initial begin
    t_reset();
    t_live();
    t_store();
    t_isolation();
    t_passthru();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule